// File: doc/BRIEF.md
# Late-Drive Bus Read Responder

This block answers the data phase of a read cycle on a slow, phase-clocked host bus. A companion sampler decodes the address half of the cycle and sends a one-clock read trigger. The responder samples the active-low select line in that same cycle. When the card is not addressed, it does nothing and waits for the next trigger. When the card is addressed, it goes busy and runs a fixed schedule from a single cycle counter. The schedule enables the data transceiver toward the bus, then turns the data pins to outputs. It takes the reply byte from a FIFO as late as it can and puts that byte on the pins. It keeps driving until a short hold has passed after the bus phase clock falls, and then releases everything.

Each point in the schedule is set as a time in nanoseconds, measured from the rise of the phase clock, and turned into a cycle count of the local clock by package functions. The trigger is taken to arrive about 130 ns into the phase. The defaults give an 8-cycle delay to the transceiver, 72 to the pin direction change, 73 to the FIFO pop and 74 to driving the byte, with a 4 ns local clock. The phase clock is brought in through a two-stage synchronizer. The hold after its fall is 12 ns in total, which is one counted cycle on top of the two synchronizer cycles.

Top module: `late_read_responder`

## Requirements
- R1: After reset `busy`, `underrun` and `fifo_pop` are 0, `data_oe` and `data_out` are all zeros, and `xcvr_ctl` is 2'b10, meaning the transceiver is disabled.
- R2: A read trigger is accepted only at a clock edge where `rd_trig` is 1 and `sel_n` is 0; `busy` reads 1 from that edge onward. A trigger that arrives while `sel_n` is 1 leaves every output unchanged.
- R3: `xcvr_ctl` becomes 2'b01 (transceiver on, toward the bus) at the 8th clock edge after the accepting edge, and stays 2'b01 until release.
- R4: `data_oe` becomes 8'hFF at the 72nd edge after the accepting edge, and stays 8'hFF until release. It is never nonzero while `xcvr_ctl` is not 2'b01.
- R5: `fifo_pop` is a single-cycle pulse. It is high during the cycle that ends with the 74th edge after acceptance, but only if `fifo_empty` is 0. The reply byte is taken from `fifo_data` at that edge.
- R6: From the 74th edge after acceptance until release, `data_out` carries the reply byte. In every other cycle it is 8'h00.
- R7: If `fifo_empty` is 1 in the pop cycle, `fifo_pop` stays 0 and the byte from the previous reply is driven again. `underrun` also becomes 1 and stays 1 until reset.
- R8: Once the responder is driving, a fall of `phase` that is set up before edge P releases the bus at edge P+3. At release `busy` goes to 0, `xcvr_ctl` goes to 2'b10, and `data_oe` and `data_out` go to all zeros.
- R9: Read triggers that arrive while `busy` is 1 are ignored. They neither restart the schedule nor start a second cycle after release.
- R10: A fall of `phase` that comes before the byte is driven does not cut the schedule short. The byte is still driven from edge 74, and the bus is released at edge 77 after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock (4 ns at the default timing) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_trig | input | 1 | One-cycle read trigger from the address sampler |
| sel_n | input | 1 | Active-low device select, sampled with the trigger |
| phase | input | 1 | Bus phase clock, asynchronous, synchronized inside |
| fifo_empty | input | 1 | Reply FIFO has no byte |
| fifo_data | input | 8 | Head byte of the reply FIFO |
| fifo_pop | output | 1 | Removes the head byte from the FIFO |
| xcvr_ctl | output | 2 | Transceiver control: 2'b01 drives toward the bus, 2'b10 disables |
| data_oe | output | 8 | Per-pin output enable of the data pins |
| data_out | output | 8 | Value driven on the data pins |
| busy | output | 1 | A read response is in progress |
| underrun | output | 1 | Sticky flag: a pop found the FIFO empty |

## Verification
Every result is due a fixed number of edges after the edge that accepts the trigger. The transceiver output is due after 8 edges, the pin direction after 72, and the pop cycle ends on edge 74. The driven byte follows on that same edge 74. Release comes three edges after a fall of `phase` becomes visible, or at edge 77 if the fall came early. The bench keeps a behavioural model that counts edges since acceptance, and it compares every output a quarter period before each rising edge. Inputs are only changed at falling edges. Directed checks then sample at exact offsets such as 75, 76 and 77 edges after acceptance, and three and four edges after a fall.

// File: rtl/rdr_pkg.sv
`timescale 1ns/1ps
package rdr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DRIVE = 2'd2,
    ST_HOLD  = 2'd3
  } rdr_state_e;

  localparam logic [1:0] XCVR_TO_BUS = 2'b01;
  localparam logic [1:0] XCVR_OFF    = 2'b10;

  // Cycles between the trigger time and an event time, both in ns.
  function automatic int cycles_after(input int event_ns, input int trig_ns, input int clk_ns);
    if (event_ns <= trig_ns) return 0;
    return (event_ns - trig_ns) / clk_ns;
  endfunction

  // Counted hold cycles once the synchronizer latency is taken out; at least one.
  function automatic int hold_cycles(input int hold_ns, input int clk_ns, input int sync_stages);
    int total;
    total = hold_ns / clk_ns;
    if (total > sync_stages) return total - sync_stages;
    return 1;
  endfunction

  // Counter width able to hold values up to and including lim.
  function automatic int count_width(input int lim);
    int w;
    w = 1;
    while ((1 << w) <= lim) w++;
    return w;
  endfunction

endpackage

// File: rtl/rdr_sync.sv
`timescale 1ns/1ps
module rdr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rdr_sequencer.sv
`timescale 1ns/1ps
module rdr_sequencer
  import rdr_pkg::*;
#(
  parameter int XCVR_CYC = 8,
  parameter int OE_CYC   = 72,
  parameter int POP_CYC  = 73,
  parameter int HOLD_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_trig,
  input  logic sel_n,
  input  logic phase_s,
  output logic busy,
  output logic xcvr_on,
  output logic pins_out,
  output logic drive_on,
  output logic ev_accept,
  output logic ev_pop_slot,
  output logic ev_fall,
  output logic ev_release
);
  localparam int DRIVE_CYC = POP_CYC + 1;
  localparam int CNT_W     = count_width(DRIVE_CYC + HOLD_CYC);
  localparam logic [CNT_W-1:0] XCVR_MARK = CNT_W'(XCVR_CYC);
  localparam logic [CNT_W-1:0] OE_MARK   = CNT_W'(OE_CYC);
  localparam logic [CNT_W-1:0] POP_MARK  = CNT_W'(POP_CYC);
  localparam logic [CNT_W-1:0] DRV_MARK  = CNT_W'(DRIVE_CYC);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  rdr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed, driving, holding, armed_done;

  assign armed   = (state_q == ST_ARMED);
  assign driving = (state_q == ST_DRIVE);
  assign holding = (state_q == ST_HOLD);

  assign ev_accept   = (state_q == ST_IDLE) && rd_trig && !sel_n;
  assign ev_pop_slot = armed && (cnt_q == POP_MARK);
  assign armed_done  = armed && (cnt_q == DRV_MARK);
  assign ev_fall     = driving && !phase_s;
  assign ev_release  = holding && (cnt_q == HOLD_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ev_accept) begin
          state_d = ST_ARMED;
          cnt_d   = '0;
        end
      end
      ST_ARMED: begin
        if (armed_done) state_d = ST_DRIVE;
        else            cnt_d   = cnt_q + 1'b1;
      end
      ST_DRIVE: begin
        if (ev_fall) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
        end
      end
      ST_HOLD: begin
        if (ev_release) state_d = ST_IDLE;
        else            cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign xcvr_on  = (armed && (cnt_q >= XCVR_MARK)) || driving || holding;
  assign pins_out = (armed && (cnt_q >= OE_MARK))   || driving || holding;
  assign drive_on = (armed && (cnt_q >= DRV_MARK))  || driving || holding;
endmodule

// File: rtl/rdr_reply.sv
`timescale 1ns/1ps
module rdr_reply #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_slot,
  input  logic              drive_on,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic [DATA_W-1:0] reply_q,
  output logic [DATA_W-1:0] data_out,
  output logic              underrun,
  output logic              ev_underrun
);
  assign fifo_pop    = pop_slot && !fifo_empty;
  assign ev_underrun = pop_slot && fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reply_q  <= '0;
      underrun <= 1'b0;
    end else begin
      if (fifo_pop)    reply_q  <= fifo_data;
      if (ev_underrun) underrun <= 1'b1;
    end
  end

  assign data_out = drive_on ? reply_q : '0;
endmodule

// File: rtl/late_read_responder.sv
`timescale 1ns/1ps
module late_read_responder
  import rdr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TRIG_NS     = 130,
  parameter int XCVR_NS     = 162,
  parameter int OE_NS       = 418,
  parameter int POP_NS      = 422,
  parameter int HOLD_NS     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_trig,
  input  logic              sel_n,
  input  logic              phase,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic [1:0]        xcvr_ctl,
  output logic [DATA_W-1:0] data_oe,
  output logic [DATA_W-1:0] data_out,
  output logic              busy,
  output logic              underrun
);
  localparam int XCVR_CYC = cycles_after(XCVR_NS, TRIG_NS, CLK_NS);
  localparam int OE_CYC   = cycles_after(OE_NS, TRIG_NS, CLK_NS);
  localparam int POP_CYC  = cycles_after(POP_NS, TRIG_NS, CLK_NS);
  localparam int HOLD_CYC = hold_cycles(HOLD_NS, CLK_NS, SYNC_STAGES);

  logic              phase_s;
  logic              xcvr_on, pins_out, drive_on;
  logic              ev_accept, ev_pop_slot, ev_fall, ev_release, ev_underrun;
  logic [DATA_W-1:0] reply_q;

  rdr_sync #(.STAGES(SYNC_STAGES)) u_phase_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (phase),
    .q     (phase_s)
  );

  rdr_sequencer #(
    .XCVR_CYC (XCVR_CYC),
    .OE_CYC   (OE_CYC),
    .POP_CYC  (POP_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_trig     (rd_trig),
    .sel_n       (sel_n),
    .phase_s     (phase_s),
    .busy        (busy),
    .xcvr_on     (xcvr_on),
    .pins_out    (pins_out),
    .drive_on    (drive_on),
    .ev_accept   (ev_accept),
    .ev_pop_slot (ev_pop_slot),
    .ev_fall     (ev_fall),
    .ev_release  (ev_release)
  );

  rdr_reply #(.DATA_W(DATA_W)) u_reply (
    .clk         (clk),
    .rst_n       (rst_n),
    .pop_slot    (ev_pop_slot),
    .drive_on    (drive_on),
    .fifo_empty  (fifo_empty),
    .fifo_data   (fifo_data),
    .fifo_pop    (fifo_pop),
    .reply_q     (reply_q),
    .data_out    (data_out),
    .underrun    (underrun),
    .ev_underrun (ev_underrun)
  );

  assign xcvr_ctl = xcvr_on ? XCVR_TO_BUS : XCVR_OFF;
  assign data_oe  = {DATA_W{pins_out}};
endmodule

// File: rtl/rdr_checker.sv
`timescale 1ns/1ps
module rdr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_trig,
  input logic              sel_n,
  input logic              fifo_empty,
  input logic [DATA_W-1:0] fifo_data,
  input logic              fifo_pop,
  input logic [1:0]        xcvr_ctl,
  input logic [DATA_W-1:0] data_oe,
  input logic [DATA_W-1:0] data_out,
  input logic              busy,
  input logic              underrun,
  input logic              ev_pop_slot,
  input logic              ev_release,
  input logic [DATA_W-1:0] reply_q
);
  assert_busy_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(rd_trig) && !$past(sel_n)));

  assert_pins_after_xcvr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe != '0) |-> (xcvr_ctl == 2'b01));

  assert_pop_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);

  assert_pop_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (busy && !fifo_empty));

  assert_drive_after_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_slot |=> (data_out == ($past(fifo_empty) ? $past(reply_q) : $past(fifo_data))));

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  assert_release_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (data_oe == '0 && data_out == '0 && xcvr_ctl == 2'b10));

  assert_busy_until_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ev_release) |=> busy);
endmodule

bind late_read_responder rdr_checker #(.DATA_W(DATA_W)) u_rdr_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_trig     (rd_trig),
  .sel_n       (sel_n),
  .fifo_empty  (fifo_empty),
  .fifo_data   (fifo_data),
  .fifo_pop    (fifo_pop),
  .xcvr_ctl    (xcvr_ctl),
  .data_oe     (data_oe),
  .data_out    (data_out),
  .busy        (busy),
  .underrun    (underrun),
  .ev_pop_slot (ev_pop_slot),
  .ev_release  (ev_release),
  .reply_q     (reply_q)
);

// File: tb/test_late_read_responder.sv
`timescale 1ns/1ps
module test_late_read_responder;
  localparam int CLK_PERIOD = 8;
  localparam int WATCHDOG   = 20000;
  // Expected schedule, in edges after the accepting edge (4 ns timing).
  localparam int E_XCVR = (162 - 130) / 4;
  localparam int E_OE   = (418 - 130) / 4;
  localparam int E_POP  = (422 - 130) / 4;
  localparam int E_DRV  = E_POP + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_trig = 1'b0;
  logic       sel_n = 1'b1;
  logic       phase = 1'b0;
  logic       fifo_empty = 1'b1;
  logic [7:0] fifo_data = 8'h00;
  logic       fifo_pop;
  logic [1:0] xcvr_ctl;
  logic [7:0] data_oe, data_out;
  logic       busy, underrun;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit running  = 1'b0;
  bit pop_pend = 1'b0;
  logic [7:0] fq[$];

  // reference model state
  int   m_mode = 0;   // 0 idle, 1 counting, 2 waiting for fall, 3 holding
  int   m_edges = 0;  // edges since accept (mode 1) or since fall seen (mode 3)
  bit   m_sync[2];
  logic [7:0] m_byte = 8'h00;
  bit   m_unr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  late_read_responder i_late_read_responder (
    .clk(clk), .rst_n(rst_n), .rd_trig(rd_trig), .sel_n(sel_n), .phase(phase),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .xcvr_ctl(xcvr_ctl), .data_oe(data_oe), .data_out(data_out),
    .busy(busy), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // behavioural model, advanced at each rising edge
  always @(posedge clk) begin
    bit seen_low;
    if (!rst_n) begin
      m_mode = 0; m_edges = 0; m_sync[0] = 0; m_sync[1] = 0; m_byte = 8'h00; m_unr = 0;
    end else begin
      seen_low = !m_sync[1];
      m_sync[1] = m_sync[0];
      m_sync[0] = phase;
      if (m_mode == 0) begin
        if (rd_trig && !sel_n) begin m_mode = 1; m_edges = 0; end
      end else if (m_mode == 1) begin
        if (m_edges == E_POP) begin
          if (fifo_empty) m_unr = 1; else m_byte = fifo_data;
        end
        if (m_edges == E_DRV) m_mode = 2; else m_edges++;
      end else if (m_mode == 2) begin
        if (seen_low) begin m_mode = 3; m_edges = 0; end
      end else begin
        m_mode = 0;  // one counted hold cycle
      end
    end
  end

  // per-cycle comparison, a quarter period before the rising edge
  always begin
    bit on, pins, drv, popx;
    @(negedge clk);
    #2;
    if (running) begin
      on   = (m_mode == 1 && m_edges >= E_XCVR) || m_mode >= 2;
      pins = (m_mode == 1 && m_edges >= E_OE)   || m_mode >= 2;
      drv  = (m_mode == 1 && m_edges >= E_DRV)  || m_mode >= 2;
      popx = (m_mode == 1 && m_edges == E_POP && !fifo_empty);
      chk(busy == (m_mode != 0), "R2/R9 busy", busy, m_mode != 0);
      chk(xcvr_ctl == (on ? 2'b01 : 2'b10), "R3 xcvr_ctl", xcvr_ctl, on ? 1 : 2);
      chk(data_oe == (pins ? 8'hFF : 8'h00), "R4 data_oe", data_oe, pins ? 8'hFF : 0);
      chk(fifo_pop == popx, "R5 fifo_pop", fifo_pop, popx);
      chk(data_out == (drv ? m_byte : 8'h00), "R6 data_out", data_out, drv ? m_byte : 0);
      chk(underrun == m_unr, "R7 underrun", underrun, m_unr);
    end
    if (fifo_pop) pop_pend = 1'b1;
  end

  // reply FIFO model
  always begin
    @(negedge clk);
    #1;
    if (pop_pend) begin
      void'(fq.pop_front());
      pop_pend = 1'b0;
    end
    fifo_empty = (fq.size() == 0);
    fifo_data  = (fq.size() == 0) ? 8'h00 : fq[0];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // returns at the falling edge just after the accepting edge
  task automatic pulse_trig(input bit sel);
    @(negedge clk);
    rd_trig = 1'b1;
    sel_n = sel;
    @(negedge clk);
    rd_trig = 1'b0;
    sel_n = 1'b1;
  endtask

  initial begin
    wait_neg(4);
    rst_n = 1'b1;
    wait_neg(1);
    #2;
    // R1 reset state
    chk(busy == 0 && underrun == 0 && fifo_pop == 0, "R1 flags", {busy, underrun, fifo_pop}, 0);
    chk(xcvr_ctl == 2'b10 && data_oe == 0 && data_out == 0, "R1 pins", {xcvr_ctl, data_oe, data_out}, 18'h20000);
    running = 1'b1;

    // R2: trigger while not selected is ignored
    phase = 1'b1;
    fq.push_back(8'hA5);
    pulse_trig(1'b1);
    wait_neg(20);
    #2;
    chk(busy == 0 && xcvr_ctl == 2'b10 && data_oe == 0, "R2 unselected", busy, 0);

    // normal read of A5, fall about 90 edges in
    pulse_trig(1'b0);
    #2;
    chk(busy == 1, "R2 accept", busy, 1);
    wait_neg(E_DRV + 1);
    #2;
    chk(data_out == 8'hA5, "R6 byte A5", data_out, 8'hA5);
    wait_neg(90 - E_DRV - 1);
    phase = 1'b0;
    wait_neg(3);
    #2;
    chk(busy == 1, "R8 still holding", busy, 1);
    wait_neg(1);
    #2;
    chk(busy == 0 && data_oe == 0 && xcvr_ctl == 2'b10, "R8 released", busy, 0);

    // R9: triggers during busy are ignored; byte 3C
    wait_neg(10);
    phase = 1'b1;
    fq.push_back(8'h3C);
    pulse_trig(1'b0);
    wait_neg(20);
    pulse_trig(1'b0);
    wait_neg(65);
    phase = 1'b0;
    wait_neg(12);
    #2;
    chk(busy == 0, "R9 no second cycle", busy, 0);

    // R7: empty FIFO at the pop, previous byte repeats
    wait_neg(5);
    phase = 1'b1;
    pulse_trig(1'b0);
    wait_neg(E_DRV + 1);
    #2;
    chk(data_out == 8'h3C, "R7 repeat byte", data_out, 8'h3C);
    chk(underrun == 1, "R7 underrun set", underrun, 1);
    wait_neg(10);
    phase = 1'b0;
    wait_neg(8);

    // R10: early fall still yields full schedule
    phase = 1'b1;
    fq.push_back(8'h5A);
    pulse_trig(1'b0);
    wait_neg(20);
    phase = 1'b0;
    wait_neg(E_DRV + 1 - 20);
    #2;
    chk(data_out == 8'h5A && busy == 1, "R10 driven after early fall", data_out, 8'h5A);
    wait_neg(76 - E_DRV - 1);
    #2;
    chk(busy == 1, "R10 busy at edge 76", busy, 1);
    wait_neg(1);
    #2;
    chk(busy == 0 && data_out == 0, "R10 released at edge 77", busy, 0);
    chk(underrun == 1, "R7 still sticky", underrun, 1);

    wait_neg(10);
    finish_run();
  end
endmodule